// File: doc/BRIEF.md
# Timer/Event Counter with Pulse Measurement

This block is an 8-bit up-counter that sits behind a small register interface. Software picks one of three counting modes:

- **Timer mode** counts a prescaled copy of the system clock.
- **Event mode** counts synchronised edges on an external pin.
- **Pulse mode** takes a single pulse-width measurement. It counts prescaled ticks while the pin holds a chosen level, and then disables itself.

When the count passes its top value it reloads from a preload register. It also latches an interrupt request and toggles a buzzer output. The buzzer output has a complementary partner, and the pair gives a square wave whose frequency is set by the preload value.

The block has two addresses. Address 0 is the count/preload address: writes go to the preload register, and reads return the live count. Address 1 is the control register. Its fields are:

| Bits | Field |
|------|-------|
| [2:0] | prescaler select |
| [3] | edge select |
| [4] | enable |
| [5] | interrupt request flag; reads back, write 1 to clear |
| [7:6] | mode |

The mode codes are:

| Code | Mode |
|------|------|
| 00 | off |
| 01 | event |
| 10 | timer |
| 11 | pulse |

The block counts only while the enable bit is 1 and the mode is not 00.

Top module: `tmr_evt_top`

## Requirements
- R1: In timer mode, with prescaler code k in control bits [2:0], the count advances once every 2^(k+1) system clocks. Code 000 divides by 2 and code 111 divides by 256.
- R2: In event mode, with edge select 0, the counter counts rising edges of the synchronised pin. With edge select 1 it counts falling edges, and a rising edge leaves the count unchanged.
- R3: When the count is FFh and a count step occurs, the counter reloads the preload value. The interrupt request flag is set in the same cycle.
- R4: A write to address 0 while the counter is stopped loads both the preload register and the count. A write while the counter is running updates only the preload, and that value is used at the next wrap.
- R5: In pulse mode with enable 1, measurement starts on a rising edge if edge select is 1, or on a falling edge if edge select is 0. Prescaled ticks are counted until the pin returns to its former level. The enable bit then clears itself, so a later pulse leaves the count unchanged.
- R6: In timer and event modes the enable bit stays set until software writes it.
- R7: The buzzer output toggles on every wrap and holds otherwise. The second buzzer output is always its complement. After reset the buzzer output is 0 and its complement is 1.
- R8: In any cycle where the count address is read with the read strobe, the count step of that cycle is discarded.
- R9: The interrupt request flag stays set until a control write with bit 5 = 1, or until the acknowledge input is pulsed.
- R10: With mode 00, or with enable 0, the count holds its value.
- R11: After reset the count, the preload, the control register and the interrupt request flag are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | 0: count/preload, 1: control |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; blocks the count step when addressing the count |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| ack_i | input | 1 | Interrupt acknowledge; clears the request flag |
| evt_pin_i | input | 1 | External event/pulse pin, asynchronous |
| irq_o | output | 1 | Interrupt request flag |
| bz_o | output | 1 | Buzzer output, toggles on wrap |
| bz_n_o | output | 1 | Complement of bz_o |

## Verification
The bench builds the block with the default parameters: an 8-bit count, a 3-bit prescaler select and a two-stage pin synchroniser.

With an 8-bit count, a wrap from a preload of FEh takes only a few cycles. A wrap from a low value, including a mid-run preload change, takes a few hundred cycles, so both cases are checked directly.

The 3-bit select reaches the full divide-by-256 range within about 500 cycles. The fixed synchroniser depth gives a known delay from a pin change to the count step, so pulse widths and edge counts are checked against exact values.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmr_mode_e;

  localparam int CTRL_PSC_LSB = 0;
  localparam int CTRL_EDGE    = 3;
  localparam int CTRL_EN      = 4;
  localparam int CTRL_IRQ     = 5;
  localparam int CTRL_MODE_LSB = 6;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) mask[i] = (i <= int'(sel_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // tick when the selected low bits are all ones
  assign tick_o = &(cnt_q | ~mask);
endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         running_i,
  input  logic         wr_pre_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] preload_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q, pre_q;
  logic         direct_load;

  assign direct_load = wr_pre_i & ~running_i;
  assign wrap_o      = step_i & ~direct_load & (cnt_q == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else begin
      if (wr_pre_i) pre_q <= wdata_i;
      if (direct_load)  cnt_q <= wdata_i;
      else if (wrap_o)  cnt_q <= pre_q;
      else if (step_i)  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign preload_o = pre_q;
endmodule

// File: rtl/tmr_buzzer.sv
module tmr_buzzer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic toggle_i,
  output logic bz_o,
  output logic bz_n_o
);
  logic bz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bz_q <= 1'b0;
    else if (toggle_i) bz_q <= ~bz_q;
  end

  assign bz_o   = bz_q;
  assign bz_n_o = ~bz_q;
endmodule

// File: rtl/tmr_evt_top.sv
module tmr_evt_top
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PSC_SEL_W   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             addr_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic             ack_i,
  input  logic             evt_pin_i,
  output logic             irq_o,
  output logic             bz_o,
  output logic             bz_n_o
);
  localparam logic ADDR_CNT  = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  tmr_mode_e            mode_q;
  logic                 en_q, edge_q, irq_q, meas_q;
  logic [PSC_SEL_W-1:0] psc_q;

  logic wr_cnt, wr_ctrl, rd_blk, running;
  logic tick, psc_clear, pin_lvl, pin_rise, pin_fall;
  logic start_evt, end_evt, pulse_done, count_src, step, wrap;
  logic [CNT_W-1:0] cnt, preload;

  assign wr_cnt  = wr_en_i & (addr_i == ADDR_CNT);
  assign wr_ctrl = wr_en_i & (addr_i == ADDR_CTRL);
  assign rd_blk  = rd_en_i & (addr_i == ADDR_CNT);
  assign running = en_q & (mode_q != MODE_OFF);

  // prescaler phase restarts whenever internal-clock counting is idle
  assign psc_clear = ~(running & ((mode_q == MODE_TIMER) |
                                  ((mode_q == MODE_PULSE) & meas_q)));

  tmr_prescaler #(.SEL_W(PSC_SEL_W)) u_psc (
    .clk_i, .rst_ni, .clear_i(psc_clear), .sel_i(psc_q), .tick_o(tick)
  );

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i(evt_pin_i),
    .level_o(pin_lvl), .rise_o(pin_rise), .fall_o(pin_fall)
  );

  assign start_evt  = edge_q ? pin_rise : pin_fall;
  assign end_evt    = edge_q ? pin_fall : pin_rise;
  assign pulse_done = running & (mode_q == MODE_PULSE) & meas_q & end_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  meas_q <= 1'b0;
    else if (!running || mode_q != MODE_PULSE)    meas_q <= 1'b0;
    else if (!meas_q && start_evt)                meas_q <= 1'b1;
    else if (meas_q && end_evt)                   meas_q <= 1'b0;
  end

  always_comb begin
    unique case (mode_q)
      MODE_EVENT: count_src = edge_q ? pin_fall : pin_rise;
      MODE_TIMER: count_src = tick;
      MODE_PULSE: count_src = tick & meas_q;
      default:    count_src = 1'b0;
    endcase
  end

  assign step = running & count_src & ~rd_blk;

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .step_i(step), .running_i(running),
    .wr_pre_i(wr_cnt), .wdata_i, .cnt_o(cnt), .preload_o(preload),
    .wrap_o(wrap)
  );

  tmr_buzzer u_bz (.clk_i, .rst_ni, .toggle_i(wrap), .bz_o, .bz_n_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      en_q   <= 1'b0;
      edge_q <= 1'b0;
      psc_q  <= '0;
    end else if (wr_ctrl) begin
      mode_q <= tmr_mode_e'(wdata_i[CTRL_MODE_LSB +: 2]);
      en_q   <= wdata_i[CTRL_EN];
      edge_q <= wdata_i[CTRL_EDGE];
      psc_q  <= wdata_i[CTRL_PSC_LSB +: PSC_SEL_W];
    end else if (pulse_done) begin
      en_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   irq_q <= 1'b0;
    else if (wrap)                                 irq_q <= 1'b1;
    else if ((wr_ctrl && wdata_i[CTRL_IRQ]) || ack_i) irq_q <= 1'b0;
  end

  assign irq_o   = irq_q;
  assign rdata_o = (addr_i == ADDR_CTRL) ?
                   CNT_W'({mode_q, irq_q, en_q, edge_q, psc_q}) : cnt;
endmodule

// File: rtl/tmr_evt_checker.sv
module tmr_evt_checker #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wrap,
  input logic         irq_o,
  input logic         bz_o,
  input logic [W-1:0] cnt,
  input logic [W-1:0] preload,
  input logic [W-1:0] wdata_i,
  input logic         wr_cnt,
  input logic         wr_ctrl,
  input logic         wr_en_i,
  input logic         running,
  input logic         rd_blk,
  input logic         pulse_done,
  input logic         en_q,
  input logic [1:0]   mode_q,
  input logic         ack_i
);
  assert_irq_on_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> irq_o);
  assert_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> cnt == $past(preload));
  assert_stopped_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cnt && !running) |=> cnt == $past(wdata_i));
  assert_preload_update_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cnt && running) |=> preload == $past(wdata_i));
  assert_one_shot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_done && !wr_ctrl) |=> !en_q);
  assert_en_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && mode_q != 2'b11 && !wr_ctrl) |=> en_q);
  assert_buzz_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> bz_o != $past(bz_o));
  assert_buzz_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(bz_o));
  assert_read_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_blk && !wr_en_i) |=> $stable(cnt));
  assert_irq_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !wrap) |=> !irq_o);
  assert_hold_stopped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && !wr_cnt) |=> $stable(cnt));
endmodule

bind tmr_evt_top tmr_evt_checker #(.W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wrap(wrap), .irq_o(irq_o), .bz_o(bz_o),
  .cnt(cnt), .preload(preload), .wdata_i(wdata_i), .wr_cnt(wr_cnt),
  .wr_ctrl(wr_ctrl), .wr_en_i(wr_en_i), .running(running), .rd_blk(rd_blk),
  .pulse_done(pulse_done), .en_q(en_q), .mode_q(mode_q), .ack_i(ack_i)
);

// File: tb/tmr_evt_top_bench.sv
module tmr_evt_top_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       addr = 1'b0, wr = 1'b0, rd = 1'b0, ack = 1'b0, pin = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       irq, bz, bz_n;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  tmr_evt_top u_tmr_evt_top (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .ack_i(ack), .evt_pin_i(pin),
    .irq_o(irq), .bz_o(bz), .bz_n_o(bz_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic stop_clear();
    reg_wr(1'b1, 8'h00);
    reg_wr(1'b0, 8'h00);
  endtask

  task automatic pin_pulse(input logic lvl, input int len);
    @(negedge clk); pin = lvl;
    repeat (len) @(negedge clk);
    pin = ~lvl;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    reg_rd(1'b0, v); check("R11 count", v, 8'h00);
    reg_rd(1'b1, v); check("R11 ctrl", v, 8'h00);
    check("R11 irq", irq, 0);
    check("R7 reset bz", bz, 0);
    check("R7 reset bz_n", bz_n, 1);
  endtask

  task automatic t_prescale();
    logic [7:0] v;
    stop_clear(); reg_wr(1'b1, 8'h90);
    repeat (10) @(negedge clk); reg_rd(1'b0, v); check("R1 div2", v, 5);
    stop_clear(); reg_wr(1'b1, 8'h92);
    repeat (40) @(negedge clk); reg_rd(1'b0, v); check("R1 div8", v, 5);
    stop_clear(); reg_wr(1'b1, 8'h97);
    repeat (512) @(negedge clk); reg_rd(1'b0, v); check("R1 div256", v, 2);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    stop_clear(); reg_wr(1'b0, 8'hFE); reg_wr(1'b1, 8'h90);
    repeat (4) @(negedge clk);
    reg_rd(1'b0, v); check("R3 reload", v, 8'hFE);
    check("R3 irq set", irq, 1);
    check("R7 bz toggled", bz, 1);
    check("R7 bz_n complement", bz_n, 0);
    repeat (4) @(negedge clk);
    reg_rd(1'b0, v); check("R3 second reload", v, 8'hFE);
    check("R7 bz back", bz, 0);
    reg_wr(1'b1, 8'h00);
    repeat (5) @(negedge clk);
    check("R9 irq held", irq, 1);
    reg_wr(1'b1, 8'h20);
    check("R9 irq w1c", irq, 0);
  endtask

  task automatic t_preload_running();
    logic [7:0] v;
    int n = 0;
    stop_clear(); reg_wr(1'b0, 8'h10);
    reg_rd(1'b0, v); check("R4 stopped load", v, 8'h10);
    reg_wr(1'b1, 8'h90);
    reg_wr(1'b0, 8'hF0);
    reg_rd(1'b0, v); check("R4 running no load", int'(v < 8'h20 && v >= 8'h10), 1);
    while (!irq && n < 2000) begin @(negedge clk); n++; end
    reg_rd(1'b0, v); check("R4 new preload at wrap", v, 8'hF0);
    reg_wr(1'b1, 8'h00);
    @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0;
    check("R9 irq ack", irq, 0);
  endtask

  task automatic t_event();
    logic [7:0] v;
    stop_clear(); reg_wr(1'b1, 8'h50);
    for (int i = 0; i < 3; i++) pin_pulse(1'b1, 4);
    reg_rd(1'b0, v); check("R2 rising count", v, 3);
    reg_rd(1'b1, v); check("R6 enable kept", v[4], 1);
    stop_clear(); reg_wr(1'b1, 8'h58);
    @(negedge clk); pin = 1'b1; repeat (6) @(negedge clk);
    reg_rd(1'b0, v); check("R2 rise ignored", v, 0);
    pin = 1'b0; repeat (6) @(negedge clk);
    reg_rd(1'b0, v); check("R2 falling count", v, 1);
  endtask

  task automatic t_pulse();
    logic [7:0] v;
    stop_clear(); reg_wr(1'b1, 8'hD8);
    pin_pulse(1'b1, 10);
    reg_rd(1'b0, v); check("R5 high width", v, 5);
    reg_rd(1'b1, v); check("R5 enable cleared", v[4], 0);
    pin_pulse(1'b1, 10);
    reg_rd(1'b0, v); check("R5 single shot", v, 5);
    stop_clear();
    @(negedge clk); pin = 1'b1; repeat (6) @(negedge clk);
    reg_wr(1'b1, 8'hD0);
    pin_pulse(1'b0, 8);
    reg_rd(1'b0, v); check("R5 low width", v, 4);
  endtask

  task automatic t_read_block();
    logic [7:0] v;
    stop_clear(); reg_wr(1'b1, 8'h90);
    addr = 1'b0; rd = 1'b1;
    repeat (10) @(negedge clk);
    reg_rd(1'b0, v); check("R8 frozen during read", v, 0);
    rd = 1'b0;
    repeat (10) @(negedge clk);
    reg_rd(1'b0, v); check("R8 resumes", v, 5);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    stop_clear(); reg_wr(1'b0, 8'h33); reg_wr(1'b1, 8'h10);
    repeat (20) @(negedge clk);
    reg_rd(1'b0, v); check("R10 mode off holds", v, 8'h33);
    reg_wr(1'b1, 8'h80);
    repeat (20) @(negedge clk);
    reg_rd(1'b0, v); check("R10 disabled holds", v, 8'h33);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_wrap();
    t_preload_running();
    t_event();
    t_pulse();
    t_read_block();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule